// File: doc/BRIEF.md
# Prescaled Core Timer with Flag and Control Register

This block is a free-running binary counter that advances by one on each cycle in which a single-cycle `tick` enable is high. It never stops and is never loaded. Two events are taken from it. The first is an overflow, which occurs each time the low eight stages wrap. The second is a periodic real-time event, which occurs when one of four successive higher stages rises. A two-bit rate field chooses that stage.

Each event sets a sticky flag. Each flag has an enable bit, and when both are 1 the matching interrupt request output is driven high. Software reaches all of this through one 8-bit register at a single address. Reads return the flags, the enables and the rate field. Writes set the enables and the rate. Writes also carry two strobe bits: writing 1 to a strobe clears one flag. The flags cannot be written directly.

The counter is `RATE_BASE + 4` stages long. With select value `s`, the real-time event repeats every `2^(RATE_BASE+s)` ticks. The default `RATE_BASE` of 14 gives periods of 2^14 to 2^17 ticks, and the value 11 selects the slowest.

Top module: `tick_timer_ctl`

## Requirements
- R1: After the asynchronous active-low reset, the counter is zero and a read returns 0x03: both flags are 0, both enables are 0 and the rate field is 11. Both interrupt requests are low.
- R2: The counter grows by exactly one on each clock edge where `tick` is 1. It holds its value on every edge where `tick` is 0.
- R3: The overflow flag is read bit 7. It sets on the tick that takes the low eight counter stages from 0xFF to 0x00. Counting from reset, this is after every 256th tick.
- R4: The rate field is read/write bits 1:0. It selects counter stage `RATE_BASE-1+sel`. The real-time flag is read bit 6. It sets on the tick where the selected stage rises from 0 to 1, which is every `2^(RATE_BASE+sel)` ticks, first after `2^(RATE_BASE+sel-1)` ticks. Changing the rate field never sets the flag by itself.
- R5: `irq_ovf` is high exactly while the overflow flag and its enable (bit 5) are both 1. `irq_rt` is high exactly while the real-time flag and its enable (bit 4) are both 1.
- R6: Writing 1 to bit 3 clears the overflow flag, and writing 1 to bit 2 clears the real-time flag. Writing 0 to either bit leaves its flag unchanged.
- R7: When a flag's set event and a clearing write fall on the same edge, the flag ends up set.
- R8: Written values of bits 7 and 6 do not change the flags. Bits 3 and 2 always read as 0. Bits 5, 4, 1 and 0 read back the last value written to them.
- R9: `reg_rdata` shows the register only while `reg_sel` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle count enable |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write when high together with `reg_sel` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_rt | output | 1 | Real-time interrupt request |

## Verification
The bench aims a clear-by-write at the very tick that overflows the counter. A design that gives the clear priority would lose that overflow event.

It switches the rate field from a stage that is low to one that is already high. A design that detects edges by comparing the previous sample of the selected tap would then raise a false real-time flag.

It holds `tick` low for many cycles just before a wrap. A counter that ignores the enable would overflow early.

It checks the slower rates at instants where a faster tap fires, to catch a select field that maps to the wrong stage. It also writes ones into the flag positions, to catch flags that can be set directly by a write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned REG_W = 8;

  // bit positions of the single register, shared by decode and read image
  localparam int unsigned B_OVF_FLAG = 7;
  localparam int unsigned B_RT_FLAG  = 6;
  localparam int unsigned B_OVF_EN   = 5;
  localparam int unsigned B_RT_EN    = 4;
  localparam int unsigned B_OVF_CLR  = 3;
  localparam int unsigned B_RT_CLR   = 2;

  typedef struct packed {
    logic       ovf_flag;
    logic       rt_flag;
    logic       ovf_en;
    logic       rt_en;
    logic [1:0] rate;
  } tmr_state_t;

  // true when bits [k-1:0] of c are all ones (k may be 0)
  function automatic logic low_all_ones(input logic [31:0] c, input int unsigned k);
    logic [31:0] m;
    m = (k >= 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 32'd1);
    return (c & m) == m;
  endfunction

  // true when the next increment of c makes bit k go 0 -> 1
  function automatic logic stage_rises(input logic [31:0] c, input int unsigned k);
    return (c[k] == 1'b0) && low_all_ones(c, k);
  endfunction

  // read image: strobe positions always read zero
  function automatic logic [REG_W-1:0] pack_image(input tmr_state_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_OVF_FLAG] = s.ovf_flag;
    v[B_RT_FLAG]  = s.rt_flag;
    v[B_OVF_EN]   = s.ovf_en;
    v[B_RT_EN]    = s.rt_en;
    v[1:0]        = s.rate;
    return v;
  endfunction

endpackage

// File: rtl/tick_chain.sv
module tick_chain #(
  parameter int unsigned CHAIN_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output logic [CHAIN_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tick_event_detect.sv
module tick_event_detect
  import tick_timer_pkg::*;
#(
  parameter int unsigned CHAIN_W   = 18,
  parameter int unsigned LOW_W     = 8,
  parameter int unsigned RATE_BASE = 14
) (
  input  logic [CHAIN_W-1:0] cnt,
  input  logic               tick,
  input  logic [1:0]         rate,
  output logic               ovf_evt,
  output logic               rt_evt
);

  localparam int unsigned N_TAPS = 4;

  logic [31:0]       cnt_ext;
  logic [N_TAPS-1:0] tap_rise;

  assign cnt_ext = {{(32-CHAIN_W){1'b0}}, cnt};

  // wrap of the low stages: they are all ones and about to advance
  assign ovf_evt = tick && low_all_ones(cnt_ext, LOW_W);

  // each candidate tap judged from the count itself, so a change of
  // select cannot fabricate an edge
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign tap_rise[g] = stage_rises(cnt_ext, RATE_BASE - 1 + g);
  end

  assign rt_evt = tick && tap_rise[rate];

endmodule

// File: rtl/tick_ctl_reg.sv
module tick_ctl_reg
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  input  logic             ovf_evt,
  input  logic             rt_evt,
  output tmr_state_t       st
);

  logic clr_ovf;
  logic clr_rt;

  assign clr_ovf = wr_stb && wdata[B_OVF_CLR];
  assign clr_rt  = wr_stb && wdata[B_RT_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.ovf_flag <= 1'b0;
      st.rt_flag  <= 1'b0;
      st.ovf_en   <= 1'b0;
      st.rt_en    <= 1'b0;
      st.rate     <= 2'b11;
    end else begin
      // set has priority over clear
      if (ovf_evt)      st.ovf_flag <= 1'b1;
      else if (clr_ovf) st.ovf_flag <= 1'b0;
      if (rt_evt)       st.rt_flag  <= 1'b1;
      else if (clr_rt)  st.rt_flag  <= 1'b0;
      if (wr_stb) begin
        st.ovf_en <= wdata[B_OVF_EN];
        st.rt_en  <= wdata[B_RT_EN];
        st.rate   <= wdata[1:0];
      end
    end
  end

endmodule

// File: rtl/tick_timer_ctl.sv
module tick_timer_ctl
  import tick_timer_pkg::*;
#(
  parameter int unsigned LOW_W     = 8,
  parameter int unsigned RATE_BASE = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_ovf,
  output logic             irq_rt
);

  localparam int unsigned CHAIN_W = RATE_BASE + 4;

  logic [CHAIN_W-1:0] cnt;
  logic               ovf_evt;
  logic               rt_evt;
  logic               wr_stb;
  tmr_state_t         st;
  logic               ovf_flag;
  logic               rt_flag;
  logic               ovf_en;
  logic               rt_en;
  logic [1:0]         rate;

  assign wr_stb   = reg_sel && reg_wr;
  assign ovf_flag = st.ovf_flag;
  assign rt_flag  = st.rt_flag;
  assign ovf_en   = st.ovf_en;
  assign rt_en    = st.rt_en;
  assign rate     = st.rate;

  tick_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt   (cnt)
  );

  tick_event_detect #(
    .CHAIN_W   (CHAIN_W),
    .LOW_W     (LOW_W),
    .RATE_BASE (RATE_BASE)
  ) u_evt (
    .cnt     (cnt),
    .tick    (tick),
    .rate    (rate),
    .ovf_evt (ovf_evt),
    .rt_evt  (rt_evt)
  );

  tick_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wdata   (reg_wdata),
    .ovf_evt (ovf_evt),
    .rt_evt  (rt_evt),
    .st      (st)
  );

  assign reg_rdata = reg_sel ? pack_image(st) : '0;
  assign irq_ovf   = ovf_flag && ovf_en;
  assign irq_rt    = rt_flag && rt_en;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CHAIN_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               reg_sel,
  input logic               reg_wr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic               irq_ovf,
  input logic               irq_rt,
  input logic [CHAIN_W-1:0] cnt,
  input logic               ovf_evt,
  input logic               rt_evt,
  input logic               ovf_flag,
  input logic               rt_flag,
  input logic               ovf_en,
  input logic               rt_en,
  input logic [1:0]         rate
);

  logic wr;
  assign wr = reg_sel && reg_wr;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CHAIN_W'($past(cnt) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  a_r4_rt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rt_evt |=> rt_flag);

  a_r4_rt_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rt_evt |-> tick);

  a_r5_irq_ovf_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> ovf_en);

  a_r5_irq_rt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rt |-> rt_en);

  a_r6_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata[3] && !ovf_evt) |=> !ovf_flag);

  a_r6_rt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata[2] && !rt_evt) |=> !rt_flag);

  a_r8_ovf_bit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata[7] && !reg_wdata[3] && !ovf_evt) |=> ovf_flag == $past(ovf_flag));

  a_r8_rt_bit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_wdata[6] && !reg_wdata[2] && !rt_evt) |=> rt_flag == $past(rt_flag));

  a_r8_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> {ovf_en, rt_en, rate} == {$past(reg_wdata[5:4]), $past(reg_wdata[1:0])});

  a_r8_strobes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata[3:2] == 2'b00);

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata == 8'h00);

endmodule

bind tick_timer_ctl tick_timer_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_ovf   (irq_ovf),
  .irq_rt    (irq_rt),
  .cnt       (cnt),
  .ovf_evt   (ovf_evt),
  .rt_evt    (rt_evt),
  .ovf_flag  (ovf_flag),
  .rt_flag   (rt_flag),
  .ovf_en    (ovf_en),
  .rt_en     (rt_en),
  .rate      (rate)
);

// File: tb/sim_tick_timer_ctl.sv
module sim_tick_timer_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_ovf;
  logic       irq_rt;

  int errors = 0;
  int checks = 0;
  int ticks  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_ctl #(.LOW_W(8), .RATE_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ovf(irq_ovf), .irq_rt(irq_rt)
  );

  // written value, expected read-back with both flags clear
  localparam logic [15:0] VEC [9] = '{
    16'hFF_33, 16'h00_00, 16'hC0_00, 16'h20_20, 16'h10_10,
    16'h01_01, 16'h02_02, 16'h0C_00, 16'h33_33
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [7:0] d);
    @(negedge clk);
    tick = t; reg_sel = w; reg_wr = w; reg_wdata = d;
    @(posedge clk);
    if (t) ticks++;
    #1;
    tick = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b0, 1'b1, d);
  endtask

  task automatic rd(output logic [7:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0;
    #1;
    v = reg_rdata;
    reg_sel = 1'b0;
    #1;
  endtask

  task automatic run_to(input int target);
    while (ticks < target) step(1'b1, 1'b0, 8'h00);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;

    // R1 reset image and request lines
    rd(v); check("R1 reset image", v, 8'h03);
    check("R1 irq lines", {6'd0, irq_ovf, irq_rt}, 8'h00);

    // R8 table of read/write pairs, no ticks so no flag can set
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][15:8]);
      rd(v);
      check("R8 readback", v, VEC[i][7:0]);
    end

    // R9 idle bus reads zero while register is nonzero
    #1; check("R9 idle read", reg_rdata, 8'h00);

    // R3 / R2 overflow timing with a gap in the enable
    wr(8'h20);
    run_to(255);
    rd(v); check("R3 no ovf at 255", {7'd0, v[7]}, 8'h00);
    repeat (40) step(1'b0, 1'b0, 8'h00);
    rd(v); check("R2 hold while tick low", {7'd0, v[7]}, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R3 ovf at 256", {7'd0, v[7]}, 8'h01);
    check("R5 irq_ovf", {7'd0, irq_ovf}, 8'h01);
    check("R4 no rt at 256", {7'd0, v[6]}, 8'h00);

    // R8 flag positions ignored, R6 wrong strobe no effect, then clear
    wr(8'hE0);
    rd(v); check("R8 flag bits ignored", v, 8'hA0);
    wr(8'h24);
    rd(v); check("R6 rt strobe leaves ovf", {7'd0, v[7]}, 8'h01);
    wr(8'h28);
    rd(v); check("R6 ovf cleared", v, 8'h20);
    check("R5 irq_ovf drops", {7'd0, irq_ovf}, 8'h00);

    // R4 fastest rate: first event after 2^(BASE-1) ticks
    wr(8'h30);
    run_to(511);
    rd(v); check("R4 no rt at 511", {7'd0, v[6]}, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R4 rt at 512", v, 8'hF0);
    check("R5 irq_rt", {7'd0, irq_rt}, 8'h01);

    // R7 clear and overflow on the same edge
    run_to(767);
    step(1'b1, 1'b1, 8'h3C);
    rd(v); check("R7 set beats clear", {6'd0, v[7:6]}, 8'h02);

    // R4 slowest rate ignores faster taps
    wr(8'h3F);
    rd(v); check("R6 both cleared", v, 8'h33);
    run_to(1536);
    rd(v); check("R4 sel11 quiet at 1536", {7'd0, v[6]}, 8'h00);
    run_to(4095);
    rd(v); check("R4 sel11 quiet at 4095", {7'd0, v[6]}, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R4 sel11 at 4096", {7'd0, v[6]}, 8'h01);

    // R4 switching to a tap that is already high sets nothing
    run_to(4696);
    wr(8'h3C);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R4 no spurious on switch", {7'd0, v[6]}, 8'h00);
    run_to(5631);
    rd(v); check("R4 sel00 quiet at 5631", {7'd0, v[6]}, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R4 sel00 at 5632", {7'd0, v[6]}, 8'h01);

    // R4 select 10
    wr(8'h3E);
    run_to(6143);
    rd(v); check("R4 sel10 quiet at 6143", {7'd0, v[6]}, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R4 sel10 at 6144", {7'd0, v[6]}, 8'h01);

    // R4 select 01
    wr(8'h3D);
    run_to(7167);
    rd(v); check("R4 sel01 quiet at 7167", {7'd0, v[6]}, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    rd(v); check("R4 sel01 at 7168", {7'd0, v[6]}, 8'h01);

    // R5 flag set but enable off
    wr(8'h10);
    rd(v); check("R5 ovf flag kept", {7'd0, v[7]}, 8'h01);
    check("R5 irq_ovf masked", {6'd0, irq_ovf, irq_rt}, 8'h01);

    // R1 reset during operation
    @(negedge clk) rst_n = 1'b0;
    #1;
    rd(v); check("R1 reset mid-run", v, 8'h03);
    check("R1 irq after reset", {6'd0, irq_ovf, irq_rt}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    ticks = 0;
    run_to(256);
    rd(v); check("R1 count restarts at zero", {7'd0, v[7]}, 8'h01);

    done = 1;
    finish_up();
  end

endmodule